// File: doc/BRIEF.md
# Merging Quad-Word Write Buffer

This block sits between a processor-side write port and the burst-write port of an SDRAM controller. Byte, halfword and word stores are collected into entries of four 32-bit words, which is the size of one SDRAM burst. Stores to the same quad-word address are merged into one entry even when they do not touch neighbouring bytes. A per-byte valid mask goes with each entry, so the burst writes only the bytes that were actually stored.

There are two entries used in ping-pong fashion. One entry collects stores while the other waits for, or performs, its burst. An entry is closed ("sealed") and queued for the burst port when a store targets a different quad word, when a read targets the quad word being collected, when an idle timer runs out, or when merging is switched off. A read is granted to memory only once no entry still holds data for its quad word. With merging off, each store becomes a burst of its own.

Top module: `wcb_merge_buf`

## Requirements
- R1: Stores to one quad word are merged into a single burst. `bw_addr` is the quad address. `bw_mask` bit 4*w+b marks byte b of word w (w = `wr_addr[1:0]`, b = `wr_be` bit). Byte i of the burst is `bw_data[8*i+7:8*i]` and holds the last value stored to it. `bw_mask` is never zero while `bw_valid` is high.
- R2: A store to a different quad word seals the collecting entry and goes into the other entry. Bursts leave in the order their entries were sealed, and no store is lost.
- R3: A read (`rd_valid`, quad address `rd_addr`) that matches the collecting entry seals that entry. `rd_grant` stays low while any entry holds data for that quad word. It rises only after the matching burst has been accepted.
- R4: A read whose quad word is held by no entry gets `rd_grant` in the same cycle and does not seal the collecting entry.
- R5: After a store is accepted with no further activity, `bw_valid` first rises T+1 clock edges after the accepting edge, where T is `tmo_reload`. Each store merged into the collecting entry restarts this count.
- R6: Driving `wb_en` low seals a collecting entry on the next edge. While `wb_en` is low, every store leaves as a burst of its own.
- R7: When neither entry can take a store, `wr_ready` is low and the store is held until an entry drains.
- R8: While `bw_valid` is high and `bw_ready` is low, `bw_valid`, `bw_addr`, `bw_data` and `bw_mask` hold their values.
- R9: After reset, `bw_valid` is low, `wr_ready` is high, and `rd_grant` is low while `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_en | input | 1 | Merging enable; low flushes and passes stores through |
| tmo_reload | input | TW (8) | Idle timeout reload value, in cycles |
| wr_valid | input | 1 | Store request |
| wr_ready | output | 1 | Store accepted when high with `wr_valid` |
| wr_addr | input | AW-2 (30) | Store word address |
| wr_data | input | 32 | Store data |
| wr_be | input | 4 | Store byte enables |
| rd_valid | input | 1 | Read request |
| rd_addr | input | AW-OFS (28) | Read quad-word address |
| rd_grant | output | 1 | Read may proceed to memory |
| bw_valid | output | 1 | Burst write pending |
| bw_ready | input | 1 | Memory side accepts the burst |
| bw_addr | output | AW-OFS (28) | Burst quad-word address |
| bw_data | output | QW*32 (128) | Burst data |
| bw_mask | output | QW*4 (16) | Burst byte-valid mask |

## Verification
Some properties are checked on every cycle:
- burst signals holding while back-pressured;
- a live mask on every burst;
- no read grant while a pending burst carries the read's quad word;
- a read hit or a disable being followed by a burst;
- stores being refused while both entries wait to drain;
- seals only acting on a collecting entry.

Other behaviours are shown only by the bench's scenarios:
- the merged byte contents;
- burst ordering across entries;
- the exact timeout latency and its restart;
- the one-burst-per-store pass-through.

// File: rtl/wcb_pkg.sv
// Shared types for the merging write buffer.
package wcb_pkg;
    // Life cycle of one buffer entry.
    typedef enum logic [1:0] {
        ENT_EMPTY  = 2'd0,
        ENT_FILL   = 2'd1,
        ENT_SEALED = 2'd2
    } ent_state_e;
endpackage

// File: rtl/wcb_timer.sv
// Idle countdown for the collecting entry.
// Reloads on each merged store and counts down while run is high.
// expired is high while run is high and the count is zero.
// Assumes the caller gives reload priority over expiry.
module wcb_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          run,
    input  logic [TW-1:0] init,
    output logic          expired
);
    logic [TW-1:0] cnt;

    // Load on a store, otherwise count down to zero while the entry holds data.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (reload)           cnt <= init;
        else if (run && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign expired = run && (cnt == '0);
endmodule

// File: rtl/wcb_entry.sv
// One quad-word entry: tag, data, byte-valid mask and state.
// Priority is clr over seal over load. The caller never clears and seals the same entry
// in one cycle, and it loads only an empty entry or a collecting entry whose tag matches.
module wcb_entry
    import wcb_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 4,
    localparam int OFS  = $clog2(QW * 4),
    localparam int WIW  = $clog2(QW),
    localparam int TAGW = AW - OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              seal,
    input  logic              clr,
    input  logic [AW-3:0]     waddr,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wbe,
    output ent_state_e        state,
    output logic [TAGW-1:0]   tag,
    output logic [QW*32-1:0]  data,
    output logic [QW*4-1:0]   mask
);
    logic [WIW-1:0] widx;
    assign widx = waddr[WIW-1:0];

    // Track state and merge enabled bytes of each accepted store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ENT_EMPTY;
            tag   <= '0;
            data  <= '0;
            mask  <= '0;
        end else if (clr) begin
            state <= ENT_EMPTY;
            mask  <= '0;
        end else if (seal) begin
            state <= ENT_SEALED;
        end else if (load) begin
            state <= ENT_FILL;
            tag   <= waddr[AW-3:WIW];
            for (int b = 0; b < 4; b++) begin
                if (wbe[b]) begin
                    data[int'(widx) * 32 + b * 8 +: 8] <= wdata[b * 8 +: 8];
                    mask[int'(widx) * 4 + b]           <= 1'b1;
                end
            end
        end
    end

    AST_SEAL_FROM_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        seal |-> state == ENT_FILL); // R2
endmodule

// File: rtl/wcb_merge_buf.sv
// Merging write buffer top.
// Two quad-word entries alternate: one collects stores while the other waits on the
// burst port. The collecting entry is sealed on a store miss, a read hit, an idle
// timeout or a disable. Reads are granted only when no entry holds their quad word.
// Assumes bw_ready is driven by a memory side that takes one whole burst per handshake.
module wcb_merge_buf
    import wcb_pkg::*;
#(
    parameter int AW = 32,
    parameter int QW = 4,
    parameter int TW = 8,
    localparam int OFS  = $clog2(QW * 4),
    localparam int WIW  = $clog2(QW),
    localparam int TAGW = AW - OFS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_en,
    input  logic [TW-1:0]     tmo_reload,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [AW-3:0]     wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [3:0]        wr_be,
    input  logic              rd_valid,
    input  logic [TAGW-1:0]   rd_addr,
    output logic              rd_grant,
    output logic              bw_valid,
    input  logic              bw_ready,
    output logic [TAGW-1:0]   bw_addr,
    output logic [QW*32-1:0]  bw_data,
    output logic [QW*4-1:0]   bw_mask
);
    ent_state_e            st   [2];
    logic [TAGW-1:0]       tg   [2];
    logic [QW*32-1:0]      dat  [2];
    logic [QW*4-1:0]       msk  [2];

    logic act;   // entry collecting stores
    logic drn;   // oldest sealed entry
    logic act_fill, act_empty, wr_hit, rd_hit_act, tmo, seal_act, accept, drain, rd_pend;
    logic [TAGW-1:0] wr_tag;

    assign wr_tag     = wr_addr[AW-3:WIW];
    assign act_fill   = (st[act] == ENT_FILL);
    assign act_empty  = (st[act] == ENT_EMPTY);
    assign wr_hit     = act_fill && (tg[act] == wr_tag);
    assign rd_hit_act = rd_valid && act_fill && (tg[act] == rd_addr);

    // Close the collecting entry on any flush condition.
    assign seal_act = act_fill && ((wr_valid && !wr_hit) || rd_hit_act || tmo || !wb_en);

    // A store enters an empty entry, or merges into a matching one that stays open.
    assign wr_ready = act_empty || (wr_hit && !seal_act);
    assign accept   = wr_valid && wr_ready;

    assign bw_valid = (st[drn] == ENT_SEALED);
    assign drain    = bw_valid && bw_ready;
    assign bw_addr  = tg[drn];
    assign bw_data  = dat[drn];
    assign bw_mask  = msk[drn];

    // Hold back a read while any entry still carries its quad word.
    always_comb begin
        rd_pend = 1'b0;
        for (int e = 0; e < 2; e++)
            if (st[e] != ENT_EMPTY && tg[e] == rd_addr) rd_pend = 1'b1;
    end
    assign rd_grant = rd_valid && !rd_pend;

    // Swap the collecting entry on a seal; advance the drain pointer on each burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
            drn <= 1'b0;
        end else begin
            if (seal_act) act <= ~act;
            if (drain)    drn <= ~drn;
        end
    end

    wcb_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .reload(accept), .run(act_fill),
        .init(tmo_reload), .expired(tmo)
    );

    for (genvar e = 0; e < 2; e++) begin : g_ent
        wcb_entry #(.AW(AW), .QW(QW)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .load (accept   && (act == 1'(e))),
            .seal (seal_act && (act == 1'(e))),
            .clr  (drain    && (drn == 1'(e))),
            .waddr(wr_addr), .wdata(wr_data), .wbe(wr_be),
            .state(st[e]), .tag(tg[e]), .data(dat[e]), .mask(msk[e])
        );
    end

    AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid && !bw_ready |=> bw_valid && $stable(bw_addr) && $stable(bw_data) && $stable(bw_mask)); // R8
    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> bw_mask != '0); // R1
    AST_RD_HIT_SEAL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_act |=> bw_valid); // R3
    AST_NO_EARLY_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && bw_valid && (bw_addr == rd_addr) |-> !rd_grant); // R3
    AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st[0] == ENT_SEALED) && (st[1] == ENT_SEALED) |-> !wr_ready); // R7
    AST_DIS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_en && act_fill |=> bw_valid); // R6
endmodule

// File: tb/wcb_merge_buf_bench.sv
module wcb_merge_buf_bench;
    localparam int CLK_NS = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wb_en = 1'b1;
    logic [7:0]   tmo_reload = 8'd50;
    logic         wr_valid = 1'b0;
    logic         wr_ready;
    logic [29:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [3:0]   wr_be = '0;
    logic         rd_valid = 1'b0;
    logic [27:0]  rd_addr = '0;
    logic         rd_grant;
    logic         bw_valid;
    logic         bw_ready = 1'b1;
    logic [27:0]  bw_addr;
    logic [127:0] bw_data;
    logic [15:0]  bw_mask;

    wcb_merge_buf u_wcb_merge_buf (
        .clk(clk), .rst_n(rst_n), .wb_en(wb_en), .tmo_reload(tmo_reload),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be), .rd_valid(rd_valid), .rd_addr(rd_addr),
        .rd_grant(rd_grant), .bw_valid(bw_valid), .bw_ready(bw_ready),
        .bw_addr(bw_addr), .bw_data(bw_data), .bw_mask(bw_mask)
    );

    always #(CLK_NS / 2) clk = ~clk;

    typedef struct packed {
        logic [27:0]  a;
        logic [127:0] d;
        logic [15:0]  m;
    } burst_t;

    burst_t       exp_q[$];
    int           n_tests = 0;
    int           n_fail  = 0;
    logic [127:0] sh_d = '0;
    logic [15:0]  sh_m = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [127:0] expand(input logic [15:0] m);
        logic [127:0] r;
        for (int i = 0; i < 16; i++) r[i*8 +: 8] = {8{m[i]}};
        return r;
    endfunction

    // Shadow model of one quad word, built from the merging rule.
    task automatic sh_put(input logic [31:0] byte_addr, input logic [3:0] be, input logic [31:0] d);
        int w;
        w = int'(byte_addr[3:2]);
        for (int b = 0; b < 4; b++)
            if (be[b]) begin
                sh_d[w*32 + b*8 +: 8] = d[b*8 +: 8];
                sh_m[w*4 + b]         = 1'b1;
            end
    endtask

    task automatic sh_push(input logic [31:0] byte_addr);
        burst_t x;
        x.a = byte_addr[31:4];
        x.d = sh_d;
        x.m = sh_m;
        exp_q.push_back(x);
        sh_d = '0;
        sh_m = '0;
    endtask

    // Driver: present a store and hold it until accepted; returns just after the accepting edge.
    task automatic do_wr(input logic [31:0] byte_addr, input logic [31:0] d, input logic [3:0] be);
        wr_valid = 1'b1;
        wr_addr  = byte_addr[31:2];
        wr_data  = d;
        wr_be    = be;
        forever begin
            @(negedge clk);
            if (wr_ready) break;
        end
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Count edges after the last accepting edge until bw_valid shows.
    task automatic measure_tmo(input int t, input string req);
        int  j = 0;
        bit  seen = 1'b0;
        while (!seen && j < 400) begin
            @(negedge clk);
            if (bw_valid) seen = 1'b1;
            else j++;
        end
        check(j == t + 1, req, "timeout latency", 128'(j), 128'(t + 1));
        @(posedge clk);
        #1;
    endtask

    // Monitor: pop the expected burst on each handshake and compare.
    always @(negedge clk) begin
        if (rst_n && bw_valid && bw_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected burst addr", 128'(bw_addr), 128'(0));
            end else begin
                burst_t e;
                e = exp_q.pop_front();
                check(bw_addr == e.a, "R2", "burst order/addr", 128'(bw_addr), 128'(e.a));
                check(bw_mask == e.m, "R1", "burst mask", 128'(bw_mask), 128'(e.m));
                check((bw_data & expand(e.m)) == e.d, "R1", "merged data",
                      bw_data & expand(e.m), e.d);
            end
        end
    end

    // Watchdog.
    initial begin
        #(CLK_NS * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL R7 watchdog expired actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(bw_valid == 1'b0, "R9", "bw_valid in reset", 128'(bw_valid), 128'(0));
        check(wr_ready == 1'b1, "R9", "wr_ready in reset", 128'(wr_ready), 128'(1));
        check(rd_grant == 1'b0, "R9", "rd_grant in reset", 128'(rd_grant), 128'(0));
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        step(1);

        // R1: non-contiguous merging into one quad word, then R2 miss flush
        sh_put(32'h100, 4'b0001, 32'h0000_0011);
        sh_put(32'h108, 4'b1100, 32'hAABB_0000);
        sh_put(32'h100, 4'b0010, 32'h0000_2200);
        sh_put(32'h10C, 4'b1000, 32'h4400_0000);
        sh_push(32'h100);
        do_wr(32'h100, 32'h0000_0011, 4'b0001);
        do_wr(32'h108, 32'hAABB_0000, 4'b1100);
        do_wr(32'h100, 32'h0000_2200, 4'b0010);
        do_wr(32'h10C, 32'h4400_0000, 4'b1000);
        sh_put(32'h204, 4'b1111, 32'h1234_5678);
        sh_push(32'h200);
        do_wr(32'h204, 32'h1234_5678, 4'b1111);

        // R3: read hit held until the write-back is accepted
        rd_addr  = 28'h20;
        rd_valid = 1'b1;
        @(negedge clk);
        check(rd_grant == 1'b0, "R3", "grant during hit", 128'(rd_grant), 128'(0));
        begin
            int k = 0;
            while (!rd_grant && k < 50) begin
                @(negedge clk);
                k++;
            end
        end
        check(rd_grant == 1'b1, "R3", "grant after flush", 128'(rd_grant), 128'(1));
        check(exp_q.size() == 0, "R3", "write-back done before grant", 128'(exp_q.size()), 128'(0));
        @(posedge clk);
        #1;
        rd_valid = 1'b0;

        // R4: read miss on an empty buffer, then with another quad word collecting
        rd_addr  = 28'h30;
        rd_valid = 1'b1;
        @(negedge clk);
        check(rd_grant == 1'b1, "R4", "grant on empty buffer", 128'(rd_grant), 128'(1));
        @(posedge clk);
        #1;
        rd_valid = 1'b0;
        sh_put(32'h700, 4'b0011, 32'h0000_BEEF);
        sh_push(32'h700);
        do_wr(32'h700, 32'h0000_BEEF, 4'b0011);
        rd_valid = 1'b1;
        @(negedge clk);
        check(rd_grant == 1'b1, "R4", "grant on miss while collecting", 128'(rd_grant), 128'(1));
        @(posedge clk);
        #1;
        rd_valid = 1'b0;
        @(negedge clk);
        check(bw_valid == 1'b0, "R4", "read miss does not flush", 128'(bw_valid), 128'(0));
        @(posedge clk);
        #1;

        // R5: timeout latency, and restart on a merged store
        tmo_reload = 8'd5;
        sh_put(32'h400, 4'b1111, 32'hCAFE_F00D);
        sh_push(32'h400);
        do_wr(32'h400, 32'hCAFE_F00D, 4'b1111);
        measure_tmo(5, "R5");
        sh_put(32'h804, 4'b0100, 32'h0055_0000);
        sh_put(32'h80C, 4'b0001, 32'h0000_0066);
        sh_push(32'h800);
        do_wr(32'h804, 32'h0055_0000, 4'b0100);
        step(3);
        do_wr(32'h80C, 32'h0000_0066, 4'b0001);
        measure_tmo(5, "R5");

        // R6: disable flushes, then one burst per store
        tmo_reload = 8'd50;
        sh_put(32'h500, 4'b0011, 32'h0000_7788);
        sh_push(32'h500);
        do_wr(32'h500, 32'h0000_7788, 4'b0011);
        wb_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(bw_valid == 1'b1, "R6", "disable flushes entry", 128'(bw_valid), 128'(1));
        @(posedge clk);
        #1;
        sh_put(32'h604, 4'b1111, 32'h1111_2222);
        sh_push(32'h600);
        sh_put(32'h608, 4'b0001, 32'h0000_0099);
        sh_push(32'h600);
        do_wr(32'h604, 32'h1111_2222, 4'b1111);
        do_wr(32'h608, 32'h0000_0099, 4'b0001);
        step(4);
        check(exp_q.size() == 0, "R6", "separate pass-through bursts", 128'(exp_q.size()), 128'(0));
        wb_en = 1'b1;
        step(1);

        // R7 / R8: both entries waiting, store stalls, burst holds
        bw_ready = 1'b0;
        sh_put(32'h900, 4'b1111, 32'h0A0A_0A0A);
        sh_push(32'h900);
        sh_put(32'hA04, 4'b1111, 32'h0B0B_0B0B);
        sh_push(32'hA00);
        sh_put(32'hB08, 4'b0110, 32'h00CC_CC00);
        sh_push(32'hB00);
        do_wr(32'h900, 32'h0A0A_0A0A, 4'b1111);
        do_wr(32'hA04, 32'h0B0B_0B0B, 4'b1111);
        fork
            do_wr(32'hB08, 32'h00CC_CC00, 4'b0110);
            begin
                repeat (4) begin
                    @(negedge clk);
                    check(wr_ready == 1'b0, "R7", "store stalls when full", 128'(wr_ready), 128'(0));
                    check(bw_valid && bw_addr == 28'h90, "R8", "burst held under back-pressure",
                          128'(bw_addr), 128'(28'h90));
                end
                @(posedge clk);
                #1;
                bw_ready = 1'b1;
            end
        join
        wb_en = 1'b0;
        step(3);
        wb_en = 1'b1;

        begin
            int k = 0;
            while (exp_q.size() != 0 && k < 300) begin
                step(1);
                k++;
            end
        end
        check(exp_q.size() == 0, "R2", "all bursts delivered in order", 128'(exp_q.size()), 128'(0));

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule